// File: doc/BRIEF.md
# Accumulator ALU with Carry and Zero Flags

This block is the arithmetic stage of a small accumulator processor. It takes a working copy of the accumulator and a second operand, and produces an 8-bit result for the processor's data bus. The second operand is either a general register value or the contents of a scratch register, chosen by a select input. A 3-bit function code picks add, subtract, one of two pass-throughs, or an operand complement.

Two flag registers sit beside the datapath. Each has its own active-low write strobe. A carry flag takes the carry-out of an add, the borrow of a subtract, or the bit shifted out of a rotate. A zero flag records whether the bus result is all zeros. A compare is a subtract with both strobes asserted while the bus result is discarded. A rotate input overrides the function code and rotates the accumulator right through the carry, so the accumulator and the carry act as one 9-bit ring.

The result path is combinational. Only the two flags are stored, and both are cleared by a synchronous active-low reset.

Top module: `acc_alu`

## Requirements
- R1: With function code 000 and no rotate, `data_o` equals (`act_i` + operand) mod 256. A carry capture stores bit 8 of the 9-bit sum.
- R2: With function code 001 and no rotate, `data_o` equals (`act_i` − operand) mod 256. A carry capture stores 1 exactly when `act_i` is less than the operand (a borrow).
- R3: Function code 010, and the unused codes 101, 110 and 111, put `act_i` on `data_o` unchanged.
- R4: Function code 011 puts the operand on `data_o` unchanged.
- R5: Function code 100 puts the bitwise complement of the operand on `data_o`.
- R6: The operand is `reg_i` when `opnd_sel_i` is 0 and `tmp_i` when it is 1.
- R7: The carry flag changes only on a rising clock edge where `cy_we_n_i` is 0. For function codes other than 000 and 001, without rotate, a capture stores 0.
- R8: The zero flag changes only on a rising clock edge where `z_we_n_i` is 0. It then stores 1 exactly when `data_o` was 00h in that cycle.
- R9: While `rrc_i` is 1, `data_o` equals {`cy_o`, `acc_i`[7:1]}, and a carry capture stores `acc_i`[0]. Nine such rotates, each feeding the result back as `acc_i`, restore the original accumulator and carry.
- R10: A rising edge with `rst_n` low clears `cy_o` and `z_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_i | input | 8 | Working copy of the accumulator (first operand) |
| reg_i | input | 8 | General register value (operand choice 0) |
| tmp_i | input | 8 | Scratch register value (operand choice 1) |
| opnd_sel_i | input | 1 | Operand select: 0 register, 1 scratch |
| func_i | input | 3 | Function code |
| acc_i | input | 8 | Accumulator value for the rotate |
| rrc_i | input | 1 | Rotate right through carry; overrides func_i |
| cy_we_n_i | input | 1 | Carry capture strobe, active low |
| z_we_n_i | input | 1 | Zero capture strobe, active low |
| data_o | output | 8 | Result to the data bus |
| cy_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |

## Verification
Add and subtract are swept over every operand pair. Off-by-one borrow sense or a dropped ninth bit shows up as a wrong carry at 255+1 or at equal operands in a compare. The unused function codes are checked against the accumulator, so a design that leaves them undriven or zero fails there. Flags are checked across cycles with the strobe held high, so a flag that tracks the result continuously is caught. A nine-step rotate chain catches a rotate that loses the carry or shifts in zero.

// File: rtl/acc_alu_pkg.sv
// Package: function codes shared by the ALU, its checker and its bench.
// Assumes the 3-bit code is fixed; codes not listed behave as pass-accumulator.
package acc_alu_pkg;
    localparam int FN_W = 3;
    localparam logic [FN_W-1:0] FN_ADD      = 3'b000;
    localparam logic [FN_W-1:0] FN_SUB      = 3'b001;
    localparam logic [FN_W-1:0] FN_PASS_ACT = 3'b010;
    localparam logic [FN_W-1:0] FN_PASS_OPD = 3'b011;
    localparam logic [FN_W-1:0] FN_NOT_OPD  = 3'b100;
endpackage

// File: rtl/acc_alu_core.sv
// Function unit: combinational result and carry source for the 3-bit code.
// Assumes the operand is already selected; carry out is 0 for non-arith codes.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   act,
    input  logic [DW-1:0]   opnd,
    input  logic [FN_W-1:0] func,
    output logic [DW-1:0]   res,
    output logic            cout
);
    logic [DW:0] sum_w;
    logic [DW:0] dif_w;

    assign sum_w = {1'b0, act} + {1'b0, opnd};
    assign dif_w = {1'b0, act} - {1'b0, opnd};

    // Purpose: pick the result and carry source from the function code.
    always_comb begin
        res  = act;
        cout = 1'b0;
        case (func)
            FN_ADD:      begin res = sum_w[DW-1:0]; cout = sum_w[DW]; end
            FN_SUB:      begin res = dif_w[DW-1:0]; cout = dif_w[DW]; end
            FN_PASS_ACT: res = act;
            FN_PASS_OPD: res = opnd;
            FN_NOT_OPD:  res = ~opnd;
            default:     res = act;
        endcase
    end
endmodule

// File: rtl/acc_alu_rot.sv
// Rotate unit: rotates the accumulator right through the carry as one ring.
// Assumes the caller decides whether the rotate result is used.
module acc_alu_rot #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] acc,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    // Purpose: carry enters the top bit; the bottom bit leaves as carry.
    always_comb begin
        res  = {cin, acc[DW-1:1]};
        cout = acc[0];
    end
endmodule

// File: rtl/acc_alu_flags.sv
// Flag store: carry and zero registers, each written on its own active-low strobe.
// Assumes synchronous active-low reset clearing both flags.
module acc_alu_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic cy_we_n,
    input  logic z_we_n,
    input  logic cy_d,
    input  logic z_d,
    output logic cy_q,
    output logic z_q
);
    // Purpose: capture carry only on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        cy_q <= 1'b0;
        else if (!cy_we_n) cy_q <= cy_d;
    end

    // Purpose: capture zero only on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       z_q <= 1'b0;
        else if (!z_we_n) z_q <= z_d;
    end
endmodule

// File: rtl/acc_alu.sv
// Top: operand select, function unit, rotate override, zero detect and flags.
// Assumes the bus driver and register writes live outside; result is combinational.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   act_i,
    input  logic [DW-1:0]   reg_i,
    input  logic [DW-1:0]   tmp_i,
    input  logic            opnd_sel_i,
    input  logic [FN_W-1:0] func_i,
    input  logic [DW-1:0]   acc_i,
    input  logic            rrc_i,
    input  logic            cy_we_n_i,
    input  logic            z_we_n_i,
    output logic [DW-1:0]   data_o,
    output logic            cy_o,
    output logic            z_o
);
    logic [DW-1:0] opnd_w;
    logic [DW-1:0] fn_res_w;
    logic          fn_cy_w;
    logic [DW-1:0] rot_res_w;
    logic          rot_cy_w;
    logic          cy_d_w;

    assign opnd_w = opnd_sel_i ? tmp_i : reg_i;

    acc_alu_core #(.DW(DW)) u_core (
        .act  (act_i),
        .opnd (opnd_w),
        .func (func_i),
        .res  (fn_res_w),
        .cout (fn_cy_w)
    );

    acc_alu_rot #(.DW(DW)) u_rot (
        .acc  (acc_i),
        .cin  (cy_o),
        .res  (rot_res_w),
        .cout (rot_cy_w)
    );

    // Purpose: the rotate overrides the function code on result and carry.
    always_comb begin
        data_o = rrc_i ? rot_res_w : fn_res_w;
        cy_d_w = rrc_i ? rot_cy_w  : fn_cy_w;
    end

    acc_alu_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cy_we_n (cy_we_n_i),
        .z_we_n  (z_we_n_i),
        .cy_d    (cy_d_w),
        .z_d     (data_o == '0),
        .cy_q    (cy_o),
        .z_q     (z_o)
    );
endmodule

// File: rtl/acc_alu_chk.sv
// Checker: temporal properties of the ALU observed at its ports, bound to acc_alu.
// Assumes synchronous active-low reset; all properties are off while in reset.
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   act_i,
    input logic [DW-1:0]   reg_i,
    input logic [DW-1:0]   tmp_i,
    input logic            opnd_sel_i,
    input logic [FN_W-1:0] func_i,
    input logic [DW-1:0]   acc_i,
    input logic            rrc_i,
    input logic            cy_we_n_i,
    input logic            z_we_n_i,
    input logic [DW-1:0]   data_o,
    input logic            cy_o,
    input logic            z_o
);
    logic [DW-1:0] opnd_c;
    logic [DW:0]   sum_c;
    assign opnd_c = opnd_sel_i ? tmp_i : reg_i;
    assign sum_c  = {1'b0, act_i} + {1'b0, opnd_c};

    p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cy_we_n_i && !rrc_i && func_i == FN_ADD) |=> cy_o == $past(sum_c[DW]));

    p_sub_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rrc_i && func_i == FN_SUB) |-> data_o == DW'(act_i - opnd_c));

    p_hold_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cy_we_n_i |=> $stable(cy_o));

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        z_we_n_i |=> $stable(z_o));

    p_zero_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !z_we_n_i |=> z_o == ($past(data_o) == '0));

    p_rot_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rrc_i |-> data_o == {cy_o, acc_i[DW-1:1]});

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!cy_o && !z_o));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_acc_alu_chk (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .reg_i(reg_i), .tmp_i(tmp_i),
    .opnd_sel_i(opnd_sel_i), .func_i(func_i), .acc_i(acc_i), .rrc_i(rrc_i),
    .cy_we_n_i(cy_we_n_i), .z_we_n_i(z_we_n_i), .data_o(data_o),
    .cy_o(cy_o), .z_o(z_o)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    import acc_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] act_i = '0, reg_i = '0, tmp_i = '0, acc_i = '0;
    logic       opnd_sel_i = 1'b0, rrc_i = 1'b0;
    logic [2:0] func_i = '0;
    logic       cy_we_n_i = 1'b1, z_we_n_i = 1'b1;
    logic [7:0] data_o;
    logic       cy_o, z_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu #(.DW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_i(act_i), .reg_i(reg_i), .tmp_i(tmp_i),
        .opnd_sel_i(opnd_sel_i), .func_i(func_i), .acc_i(acc_i), .rrc_i(rrc_i),
        .cy_we_n_i(cy_we_n_i), .z_we_n_i(z_we_n_i), .data_o(data_o),
        .cy_o(cy_o), .z_o(z_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clocked step: drive at negedge, flags read after the next posedge.
    task automatic step(input logic [2:0] fn, input logic [7:0] a, input logic [7:0] b,
                        input logic cw, input logic zw);
        @(negedge clk);
        func_i = fn; act_i = a; reg_i = b; opnd_sel_i = 1'b0; rrc_i = 1'b0;
        cy_we_n_i = cw; z_we_n_i = zw;
        @(posedge clk); #1;
        cy_we_n_i = 1'b1; z_we_n_i = 1'b1;
    endtask

    initial begin
        int exp_cy;
        logic [8:0] ring;
        // R10 reset
        repeat (2) @(posedge clk); #1;
        chk(cy_o == 1'b0, "R10 carry", cy_o, 0);
        chk(z_o == 1'b0, "R10 zero", z_o, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 exhaustive result sweep, combinational
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                act_i = 8'(a); reg_i = 8'(b); opnd_sel_i = 1'b0;
                func_i = FN_ADD; #1;
                chk(data_o == 8'((a + b) & 255), "R1 sum", data_o, (a + b) & 255);
                func_i = FN_SUB; #1;
                chk(data_o == 8'((a - b) & 255), "R2 diff", data_o, (a - b) & 255);
            end
        end

        // R3 R4 R5 R6 code sweep with both operand sources
        for (int a = 0; a < 256; a += 7) begin
            for (int s = 0; s < 2; s++) begin
                act_i = 8'(a); reg_i = 8'(a ^ 8'h5A); tmp_i = 8'(a + 33);
                opnd_sel_i = s[0];
                func_i = FN_PASS_ACT; #1;
                chk(data_o == 8'(a), "R3 pass act", data_o, a);
                for (int u = 5; u < 8; u++) begin
                    func_i = 3'(u); #1;
                    chk(data_o == 8'(a), "R3 unused code", data_o, a);
                end
                func_i = FN_PASS_OPD; #1;
                chk(data_o == (s ? 8'(a + 33) : 8'(a ^ 8'h5A)), "R6 operand select",
                    data_o, s ? ((a + 33) & 255) : (a ^ 8'h5A));
                chk(data_o == (s ? tmp_i : reg_i), "R4 pass operand", data_o, s ? tmp_i : reg_i);
                func_i = FN_NOT_OPD; #1;
                chk(data_o == ~(s ? tmp_i : reg_i), "R5 complement", data_o, ~(s ? tmp_i : reg_i));
            end
        end

        // R1 R2 R8 flag captures over a grid
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 15) begin
                step(FN_ADD, 8'(a), 8'(b), 1'b0, 1'b0);
                chk(cy_o == ((a + b) > 255), "R1 carry", cy_o, (a + b) > 255);
                chk(z_o == (((a + b) & 255) == 0), "R8 zero add", z_o, ((a + b) & 255) == 0);
                step(FN_SUB, 8'(a), 8'(b), 1'b0, 1'b0);
                chk(cy_o == (a < b), "R2 borrow", cy_o, a < b);
                chk(z_o == (a == b), "R8 zero compare", z_o, a == b);
            end
        end
        // corners: 255+1 and equal compare
        step(FN_ADD, 8'hFF, 8'h01, 1'b0, 1'b0);
        chk(cy_o == 1'b1 && z_o == 1'b1, "R1 wrap corner", {cy_o, z_o}, 3);
        step(FN_SUB, 8'h00, 8'h01, 1'b0, 1'b0);
        chk(cy_o == 1'b1 && z_o == 1'b0, "R2 borrow corner", {cy_o, z_o}, 2);

        // R7 R8 hold without strobes
        step(FN_ADD, 8'hFF, 8'h01, 1'b0, 1'b0);
        step(FN_SUB, 8'h10, 8'h01, 1'b1, 1'b1);
        chk(cy_o == 1'b1, "R7 carry hold", cy_o, 1);
        chk(z_o == 1'b1, "R8 zero hold", z_o, 1);
        step(FN_ADD, 8'h00, 8'h00, 1'b1, 1'b0);
        chk(cy_o == 1'b1, "R7 carry hold with zero strobe", cy_o, 1);
        step(FN_PASS_ACT, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(cy_o == 1'b0, "R7 non-arith clears carry", cy_o, 0);
        step(FN_NOT_OPD, 8'h00, 8'hFF, 1'b1, 1'b0);
        chk(z_o == 1'b1, "R8 zero on complement", z_o, 1);

        // R9 nine-step rotate ring
        step(FN_ADD, 8'hFF, 8'h01, 1'b0, 1'b1);
        ring = {1'b1, 8'hA6};
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            acc_i = ring[7:0]; rrc_i = 1'b1; func_i = FN_ADD; cy_we_n_i = 1'b0; #1;
            chk(data_o == ring[8:1], "R9 rotate data", data_o, ring[8:1]);
            exp_cy = ring[0];
            ring = {ring[0], ring[8:1]};
            @(posedge clk); #1;
            cy_we_n_i = 1'b1;
            chk(cy_o == exp_cy[0], "R9 rotate carry", cy_o, exp_cy);
        end
        chk(ring == {1'b1, 8'hA6} && cy_o == 1'b1 && data_o == 8'hA6, "R9 ring restored",
            {cy_o, data_o}, 9'h1A6);
        rrc_i = 1'b0;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule